// File: doc/BRIEF.md
# Dual-Path Over-Range Detector

This block raises an alarm when a converter's input leaves its usable range. It watches two things at once. Each signed sample coming out of the first decimation stage is reduced to its magnitude and compared against a programmable 16-bit limit. The comparison happens before any gain or offset correction, so the answer is available one clock after the sample arrives. In parallel, a run-length tracker watches the per-modulator-sample full-scale flag. It raises the alarm as soon as the modulator has sat at full scale for more than a set number of consecutive samples. That catches hard clipping long before a filtered sample could show it.

The alarm is a single registered flag. It drives both an external pin and a status bit that always carries the same value. A full-scale run forces the flag high. When no run is active, each valid first-stage sample sets the flag high or low according to its comparison. Between samples the flag holds its value. The limit is held in a register that loads a default of 80 % of full scale on reset and can be rewritten through a write strobe.

Top module: `overrange_monitor`

## Requirements
- R1: A synchronous active-high reset drives both alarm outputs low, clears the run count and loads the limit with 0xCCCC.
- R2: A valid sample whose magnitude, shifted right by 7 bits (the 16 magnitude bits just below the sign position of a 24-bit sample), is greater than the limit drives alarm_pin high on the clock edge that takes the sample. alarm_status equals alarm_pin in every cycle.
- R3: A negative sample is judged by its absolute value. The most negative code 0x800000 is treated as magnitude 0x7FFFFF.
- R4: The comparison is strict. A magnitude whose shifted value equals the limit (for example 0x666600 against 0xCCCC) is in range, and 0x666680 is over range.
- R5: When mod_valid is high with mod_full high for the 5th consecutive time, alarm_pin goes high on that same edge. Four consecutive full-scale samples alone do not raise it.
- R6: A mod_valid strobe with mod_full low restarts the run count. Cycles with mod_valid low leave the count unchanged.
- R7: With no run active, the first valid in-range sample clears the alarm on the edge that takes it. While a run is active, in-range samples do not clear it.
- R8: Samples offered with samp_valid low are ignored, and the alarm holds its value.
- R9: A limit written with thr_wr takes effect from the next cycle. A sample presented in the same cycle as the write is compared against the old limit.
- R10: The run count saturates and does not wrap. A run of any length keeps the alarm high until a non-full-scale strobe arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one modulator sample slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| samp_valid | input | 1 | Strobe marking a first-stage sample |
| samp_data | input | 24 | Signed first-stage sample, two's complement |
| mod_valid | input | 1 | Strobe marking a modulator sample |
| mod_full | input | 1 | Modulator sample is at full scale |
| thr_wr | input | 1 | Load thr_value into the limit register |
| thr_value | input | 16 | New limit value |
| alarm_pin | output | 1 | Registered over-range alarm |
| alarm_status | output | 1 | Status copy of the alarm |

## Verification
Positive and negative samples on both sides of the limit show whether the magnitude is formed correctly. The codes 0x666600 and 0x666680 separate a strict comparison from an inclusive one, and the most negative code with limits 0xFFFE and 0xFFFF shows whether saturation is applied. Runs of four and five full-scale strobes, broken runs, runs with idle gaps and a twelve-sample run carrying in-range samples separate off-by-one, reset-on-gap and wrap-around faults in the run tracker. Invalid samples and a limit write in the same cycle as a sample check holding and write timing.

// File: rtl/orm_pkg.sv
package orm_pkg;
  localparam int SAMPLE_W_DEF  = 24;
  localparam int THR_W_DEF     = 16;
  localparam int RUN_LIMIT_DEF = 4;
  localparam logic [THR_W_DEF-1:0] THR_RESET_DEF = 16'hCCCC;
endpackage

// File: rtl/orm_level_cmp.sv
module orm_level_cmp #(
  parameter int SAMPLE_W = 24,
  parameter int THR_W    = 16,
  parameter logic [THR_W-1:0] THR_RESET = '1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                thr_wr,
  input  logic [THR_W-1:0]    thr_value,
  input  logic [SAMPLE_W-1:0] sample,
  output logic                above
);
  localparam int LSB_PAD = SAMPLE_W - 1 - THR_W;
  localparam logic [SAMPLE_W-1:0] NEG_MIN = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-1:0] POS_MAX = ~NEG_MIN;

  logic [THR_W-1:0]    thr_q;
  logic [SAMPLE_W-1:0] mag;
  logic [SAMPLE_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst)         thr_q <= THR_RESET;
    else if (thr_wr) thr_q <= thr_value;
  end

  // absolute value, most negative code saturated to the largest positive one
  always_comb begin
    if (sample == NEG_MIN)        mag = POS_MAX;
    else if (sample[SAMPLE_W-1])  mag = -sample;
    else                          mag = sample;
  end

  // limit aligned under the sign bit, low bits filled so that only the
  // aligned window decides
  generate
    if (LSB_PAD > 0) begin : g_pad
      assign limit = {1'b0, thr_q, {LSB_PAD{1'b1}}};
    end else if (LSB_PAD == 0) begin : g_exact
      assign limit = {1'b0, thr_q};
    end else begin : g_trunc
      assign limit = {1'b0, thr_q[THR_W-1 -: SAMPLE_W-1]};
    end
  endgenerate

  assign above = mag > limit;

  AST_THR_LOAD: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> thr_q == $past(thr_value)) else $error("limit load"); // R9
endmodule

// File: rtl/orm_run_track.sv
module orm_run_track #(
  parameter int RUN_LIMIT = 4,
  parameter int CNT_W     = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic mod_valid,
  input  logic mod_full,
  output logic run_now
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LIMIT_C = CNT_W'(RUN_LIMIT);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (mod_valid) begin
      if (!mod_full)              cnt_d = '0;
      else if (cnt_q != CNT_MAX)  cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  // look at the count including the current strobe so the alarm is immediate
  assign run_now = cnt_d > LIMIT_C;

  AST_RUN_CLEAR: assert property (@(posedge clk) disable iff (rst)
    mod_valid && !mod_full |=> cnt_q == '0) else $error("run clear"); // R6
  AST_CNT_SAT: assert property (@(posedge clk) disable iff (rst)
    mod_valid && mod_full && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX) else $error("count wrap"); // R10
endmodule

// File: rtl/overrange_monitor.sv
module overrange_monitor
  import orm_pkg::*;
#(
  parameter int SAMPLE_W  = SAMPLE_W_DEF,
  parameter int THR_W     = THR_W_DEF,
  parameter int RUN_LIMIT = RUN_LIMIT_DEF,
  parameter logic [THR_W-1:0] THR_RESET = THR_RESET_DEF
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                samp_valid,
  input  logic [SAMPLE_W-1:0] samp_data,
  input  logic                mod_valid,
  input  logic                mod_full,
  input  logic                thr_wr,
  input  logic [THR_W-1:0]    thr_value,
  output logic                alarm_pin,
  output logic                alarm_status
);
  localparam int CNT_W = $clog2(RUN_LIMIT + 2);

  logic above;
  logic run_now;
  logic flag_q;

  orm_level_cmp #(
    .SAMPLE_W (SAMPLE_W),
    .THR_W    (THR_W),
    .THR_RESET(THR_RESET)
  ) u_cmp (
    .clk      (clk),
    .rst      (rst),
    .thr_wr   (thr_wr),
    .thr_value(thr_value),
    .sample   (samp_data),
    .above    (above)
  );

  orm_run_track #(
    .RUN_LIMIT(RUN_LIMIT),
    .CNT_W    (CNT_W)
  ) u_run (
    .clk      (clk),
    .rst      (rst),
    .mod_valid(mod_valid),
    .mod_full (mod_full),
    .run_now  (run_now)
  );

  always_ff @(posedge clk) begin
    if (rst)             flag_q <= 1'b0;
    else if (run_now)    flag_q <= 1'b1;
    else if (samp_valid) flag_q <= above;
  end

  assign alarm_pin    = flag_q;
  assign alarm_status = flag_q;

  AST_RUN_RAISES: assert property (@(posedge clk) disable iff (rst)
    run_now |=> alarm_pin) else $error("run raise"); // R5
  AST_IN_RANGE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    samp_valid && !run_now && !above |=> !alarm_pin) else $error("in-range clear"); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !samp_valid && !run_now |=> $stable(alarm_pin)) else $error("idle hold"); // R8
endmodule

// File: tb/overrange_monitor_tb.sv
module overrange_monitor_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic samp_valid = 1'b0;
  logic [23:0] samp_data = '0;
  logic mod_valid = 1'b0;
  logic mod_full = 1'b0;
  logic thr_wr = 1'b0;
  logic [15:0] thr_value = '0;
  logic alarm_pin, alarm_status;

  int checks = 0;
  int bad = 0;
  string cur_req = "R1";
  bit started = 0;

  // reference model state
  int m_run = 0;
  int m_thr = 0;
  bit m_flag = 0;

  always #10 clk = ~clk;

  overrange_monitor u_dut (
    .clk(clk), .rst(rst), .samp_valid(samp_valid), .samp_data(samp_data),
    .mod_valid(mod_valid), .mod_full(mod_full), .thr_wr(thr_wr),
    .thr_value(thr_value), .alarm_pin(alarm_pin), .alarm_status(alarm_status)
  );

  always @(posedge clk) begin
    int sv, mag;
    if (rst) begin
      m_run = 0; m_flag = 0; m_thr = 'hCCCC;
    end else begin
      if (mod_valid) m_run = mod_full ? m_run + 1 : 0;
      sv = $signed(samp_data);
      mag = (sv < 0) ? -sv : sv;
      if (mag > 8388607) mag = 8388607;
      if (m_run > 4) m_flag = 1;
      else if (samp_valid) m_flag = ((mag >>> 7) > m_thr);
      if (thr_wr) m_thr = thr_value;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started) begin
      checks++;
      if (alarm_pin !== m_flag) begin
        bad++;
        $display("FAIL %s: alarm_pin=%b expected %b", cur_req, alarm_pin, m_flag);
      end
      checks++;
      if (alarm_status !== m_flag) begin
        bad++;
        $display("FAIL R2: alarm_status=%b expected %b", alarm_status, m_flag);
      end
    end
  end

  task automatic step(input bit sv_i, input int data, input bit mv, input bit mf,
                      input bit wr = 0, input int wv = 0);
    samp_valid = sv_i; samp_data = 24'(data);
    mod_valid = mv; mod_full = mf; thr_wr = wr; thr_value = 16'(wv);
    @(negedge clk);
  endtask

  task automatic expect_pin(input string req, input bit exp);
    checks++;
    if (alarm_pin !== exp) begin
      bad++;
      $display("FAIL %s: alarm_pin=%b expected %b", req, alarm_pin, exp);
    end
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(0, 0, 0, 0);
    rst = 1'b0;
    expect_pin("R1", 0);
    // R1: default limit 0xCCCC, judged through the ports
    cur_req = "R4";
    step(1, 'h666600, 0, 0); expect_pin("R4", 0);
    step(1, 'h666680, 0, 0); expect_pin("R4", 1);
    step(1, 'h666600, 0, 0); expect_pin("R1", 0);
    cur_req = "R2";
    step(1, 'h700000, 0, 0); expect_pin("R2", 1);
    step(1, 'h100000, 0, 0); expect_pin("R7", 0);
    cur_req = "R3";
    step(1, -'h700000, 0, 0); expect_pin("R3", 1);
    step(1, -'h100000, 0, 0); expect_pin("R3", 0);
    step(0, 0, 0, 0, 1, 'hFFFE);
    step(1, 'h800000, 0, 0); expect_pin("R3", 1);
    step(0, 0, 0, 0, 1, 'hFFFF);
    step(1, 'h800000, 0, 0); expect_pin("R3", 0);
    cur_req = "R9";
    step(1, 'h700000, 0, 0, 1, 'hCCCC); expect_pin("R9", 0);
    step(1, 'h700000, 0, 0); expect_pin("R9", 1);
    cur_req = "R8";
    step(0, 'h000010, 0, 0); expect_pin("R8", 1);
    step(0, 'h000010, 0, 0); expect_pin("R8", 1);
    step(1, 'h000010, 0, 0); expect_pin("R7", 0);
    step(0, 'h7FFFFF, 0, 0); expect_pin("R8", 0);
    cur_req = "R5";
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);
    expect_pin("R5", 0);
    step(0, 0, 1, 1); expect_pin("R5", 1);
    step(1, 'h10, 1, 1); expect_pin("R7", 1);
    step(0, 0, 1, 0); expect_pin("R7", 1);
    step(0, 0, 0, 0); expect_pin("R7", 1);
    step(1, 'h10, 0, 0); expect_pin("R7", 0);
    cur_req = "R6";
    step(0, 0, 1, 1); step(0, 0, 1, 1);
    step(0, 0, 0, 0); step(0, 0, 0, 1); step(0, 0, 0, 0);
    step(0, 0, 1, 1); step(0, 0, 1, 1); expect_pin("R6", 0);
    step(0, 0, 1, 1); expect_pin("R6", 1);
    step(1, 'h10, 1, 0); expect_pin("R6", 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);
    step(0, 0, 1, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 1);
    expect_pin("R6", 0);
    step(1, 'h10, 1, 0);
    cur_req = "R10";
    for (int i = 0; i < 12; i++) begin
      step(1, 'h10, 1, 1);
      if (i >= 4) expect_pin("R10", 1);
    end
    step(1, 'h10, 1, 0); expect_pin("R10", 0);
    cur_req = "R1";
    rst = 1'b1;
    step(1, 'h7FFFFF, 1, 1);
    rst = 1'b0;
    expect_pin("R1", 0);
    step(1, 'h666680, 0, 0); expect_pin("R1", 1);
    step(0, 0, 0, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule